// File: doc/BRIEF.md
# Prescaled Timer and Event Counter

This unit supplies the time base and event counting for a small 4-bit controller core. A free-running prescaler advances on each instruction-cycle strobe and wraps modulo 64. A 4-bit counter advances from one of two sources, chosen by a mode flag:

- In timer mode it advances when the prescaler wraps.
- In event mode it advances on each falling edge of an external line. That line passes through a synchroniser first.

When the counter rolls over from 15 to 0 it raises a sticky overflow request. The request stays high until the core clears it. The core can also write the counter directly through a load port and set the mode flag through a write port. While the core is halted its instruction clock stops, so the prescaler freezes. External events are still counted during a halt.

No data stream crosses this block, so it has no valid/ready handshake. Every pin is a plain control or status signal, sampled or updated on each clock edge. The core must present a new load value or mode value only as a single-cycle write pulse.

Top module: `evtmr_top`

## Requirements
- R1: Each clock edge that sees `cyc_stb` high and `halt` low advances `pre_o` by one, modulo 64 (63 is followed by 0); edges without a strobe leave it unchanged.
- R2: While `halt` is high, `pre_o` does not change regardless of `cyc_stb`.
- R3: With `mode_o` = 0 (timer mode), `cnt_o` advances by one on exactly the edge where `pre_o` goes from 63 to 0, and at no other time.
- R4: With `mode_o` = 1 (event mode), `cnt_o` advances by one for each high-to-low transition of `ev_in`, visible after the third clock edge following the transition; rising edges and prescaler wraps do not change it.
- R5: In event mode, falling edges of `ev_in` are counted while `halt` is high.
- R6: `cnt_o` is 4 bits and wraps from 15 to 0 on an increment.
- R7: An increment from 15 to 0 sets `ovf_o`. The flag then stays high until a cycle with `ovf_clr` high and no new wrap; if a wrap and `ovf_clr` fall on the same edge, `ovf_o` ends high.
- R8: `ld_en` high writes `ld_val` into `cnt_o` on that edge and wins over a same-edge increment; a load never sets `ovf_o`.
- R9: `mode_we` high writes `mode_d` into `mode_o` (0 = timer, 1 = event); after reset, `pre_o`, `cnt_o`, `mode_o` and `ovf_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_stb | input | 1 | One pulse per instruction cycle |
| halt | input | 1 | Core halted; stops the instruction clock |
| ev_in | input | 1 | Asynchronous external event line |
| mode_we | input | 1 | Write strobe for the mode flag |
| mode_d | input | 1 | New mode value (0 timer, 1 event) |
| ld_en | input | 1 | Counter load strobe |
| ld_val | input | 4 | Counter load value |
| ovf_clr | input | 1 | Clear the overflow request |
| pre_o | output | 6 | Prescaler value |
| cnt_o | output | 4 | Counter value |
| mode_o | output | 1 | Current mode flag |
| ovf_o | output | 1 | Sticky overflow request |

## Verification
The hardest cases to reach are the edges where two actions land on the same clock edge. One is a load or an overflow clear arriving on the same edge as an increment. The other is an event arriving while the core is halted. The event path has a fixed three-edge delay from the pin, which the stimulus exploits. It drops `ev_in`, waits exactly two edges, and then drives the load or clear pulse so that it meets the increment on the third edge. The 63-to-0 prescaler boundary is reached by counting strobes from reset, with idle cycles mixed in between strobes.

// File: rtl/evtmr_pkg.sv
package evtmr_pkg;
  localparam int PRE_BITS = 6;
  localparam int CNT_BITS = 4;
  localparam int SYNC_DEPTH = 2;

  typedef enum logic {
    SRC_TIMER = 1'b0,
    SRC_EVENT = 1'b1
  } cnt_src_e;
endpackage

// File: rtl/evtmr_prescaler.sv
module evtmr_prescaler #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  output logic [W-1:0] pre,
  output logic         wrap
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre <= '0;
    else if (tick) pre <= pre + 1'b1;
  end

  assign wrap = tick && (pre == TOP);

  // R1
  pre_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> pre == W'($past(pre) + 1'b1));

  // R1
  pre_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(pre));
endmodule

// File: rtl/evtmr_edge_sync.sv
module evtmr_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              last;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b0;
          else chain[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= 1'b0;
          else chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last <= 1'b0;
    else last <= chain[STAGES-1];
  end

  assign fall = last && !chain[STAGES-1];

  // R4
  fall_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !fall);
endmodule

// File: rtl/evtmr_counter.sv
module evtmr_counter #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic         clr,
  output logic [W-1:0] cnt,
  output logic         ovf
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  logic rollover;
  assign rollover = inc && !ld && (cnt == TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (ld) cnt <= ld_val;
    else if (inc) cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovf <= 1'b0;
    else if (rollover) ovf <= 1'b1;
    else if (clr) ovf <= 1'b0;
  end

  // R8
  load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> cnt == $past(ld_val));

  // R6
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !ld) |=> cnt == W'($past(cnt) + 1'b1));

  // R7
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !clr) |=> ovf);

  // R7
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !ld && cnt == TOP) |=> ovf && cnt == '0);
endmodule

// File: rtl/evtmr_top.sv
module evtmr_top
  import evtmr_pkg::*;
#(
  parameter int PW = PRE_BITS,
  parameter int CW = CNT_BITS,
  parameter int SD = SYNC_DEPTH
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cyc_stb,
  input  logic          halt,
  input  logic          ev_in,
  input  logic          mode_we,
  input  logic          mode_d,
  input  logic          ld_en,
  input  logic [CW-1:0] ld_val,
  input  logic          ovf_clr,
  output logic [PW-1:0] pre_o,
  output logic [CW-1:0] cnt_o,
  output logic          mode_o,
  output logic          ovf_o
);
  cnt_src_e src_q;
  logic     tick, pre_wrap, ev_fall, bump;

  assign tick = cyc_stb && !halt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) src_q <= SRC_TIMER;
    else if (mode_we) src_q <= cnt_src_e'(mode_d);
  end

  evtmr_prescaler #(.W(PW)) u_pre (
    .clk(clk), .rst_n(rst_n), .tick(tick), .pre(pre_o), .wrap(pre_wrap)
  );

  evtmr_edge_sync #(.STAGES(SD)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(ev_in), .fall(ev_fall)
  );

  assign bump = (src_q == SRC_EVENT) ? ev_fall : pre_wrap;

  evtmr_counter #(.W(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .inc(bump), .ld(ld_en), .ld_val(ld_val),
    .clr(ovf_clr), .cnt(cnt_o), .ovf(ovf_o)
  );

  assign mode_o = (src_q == SRC_EVENT);

  // R2
  halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> $stable(pre_o));

  // R5
  halt_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && mode_o && ev_fall && !ld_en) |=> cnt_o == CW'($past(cnt_o) + 1'b1));

  // R3
  timer_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_o && !pre_wrap && !ld_en) |=> $stable(cnt_o));
endmodule

// File: tb/tb_evtmr_top.sv
`timescale 1ns/1ps
module tb_evtmr_top;
  logic       clk = 0, rst_n = 0, cyc_stb = 0, halt = 0, ev_in = 1;
  logic       mode_we = 0, mode_d = 0, ld_en = 0, ovf_clr = 0;
  logic [3:0] ld_val = 0;
  logic [5:0] pre_o;
  logic [3:0] cnt_o;
  logic       mode_o, ovf_o;
  int total = 0, bad = 0;
  int exp_pre = 0;

  always #2.5 clk = ~clk;

  evtmr_top dut (
    .clk(clk), .rst_n(rst_n), .cyc_stb(cyc_stb), .halt(halt), .ev_in(ev_in),
    .mode_we(mode_we), .mode_d(mode_d), .ld_en(ld_en), .ld_val(ld_val),
    .ovf_clr(ovf_clr), .pre_o(pre_o), .cnt_o(cnt_o), .mode_o(mode_o), .ovf_o(ovf_o)
  );

  task automatic chk(input string req, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  // one clock edge; pulse inputs are cleared after it
  task automatic cyc(input logic stb);
    cyc_stb = stb;
    @(posedge clk); #1;
    if (stb && !halt) exp_pre = (exp_pre + 1) % 64;
    cyc_stb = 0; ld_en = 0; ovf_clr = 0; mode_we = 0;
  endtask

  task automatic ev_pulse();
    ev_in = 0;
    for (int i = 0; i < 4; i++) cyc(0);
    ev_in = 1;
    for (int i = 0; i < 4; i++) cyc(0);
  endtask

  task automatic t_reset();
    rst_n = 0; ev_in = 1; halt = 0;
    repeat (2) @(posedge clk);
    #1; rst_n = 1; exp_pre = 0;
    chk("R9 reset pre", pre_o, 0);
    chk("R9 reset cnt", cnt_o, 0);
    chk("R9 reset mode", mode_o, 0);
    chk("R9 reset ovf", ovf_o, 0);
  endtask

  task automatic t_prescale();
    for (int i = 0; i < 10; i++) cyc(1);
    chk("R1 dense strobes", pre_o, exp_pre);
    for (int i = 0; i < 5; i++) begin cyc(1); cyc(0); end
    chk("R1 sparse strobes", pre_o, 15);
    for (int i = 0; i < 48; i++) cyc(1);
    chk("R1 at 63", pre_o, 63);
    chk("R3 no count before wrap", cnt_o, 0);
    cyc(1);
    chk("R1 wraps to 0", pre_o, 0);
    chk("R3 count on wrap", cnt_o, 1);
  endtask

  task automatic t_halt();
    for (int i = 0; i < 5; i++) cyc(1);
    halt = 1;
    for (int i = 0; i < 8; i++) cyc(1);
    chk("R2 halted pre frozen", pre_o, 5);
    halt = 0;
    cyc(1);
    chk("R2 resumes", pre_o, 6);
  endtask

  task automatic t_event();
    int base;
    mode_d = 1; mode_we = 1; cyc(0);
    chk("R9 mode write", mode_o, 1);
    for (int i = 0; i < 4; i++) cyc(0);
    base = cnt_o;
    ev_in = 0; cyc(0); cyc(0);
    chk("R4 not yet after two edges", cnt_o, base);
    cyc(0);
    chk("R4 count on third edge", cnt_o, base + 1);
    ev_in = 1; for (int i = 0; i < 4; i++) cyc(0);
    chk("R4 rising edge ignored", cnt_o, base + 1);
    ev_pulse(); ev_pulse();
    chk("R4 three falls", cnt_o, base + 3);
    for (int i = 0; i < 70; i++) cyc(1);
    chk("R4 prescaler wrap ignored", cnt_o, base + 3);
    halt = 1;
    ev_pulse();
    chk("R5 counted while halted", cnt_o, base + 4);
    halt = 0;
  endtask

  task automatic t_load();
    ld_val = 5; ld_en = 1; cyc(0);
    chk("R8 load value", cnt_o, 5);
    ev_in = 0; cyc(0); cyc(0);
    ld_val = 9; ld_en = 1; cyc(0);
    chk("R8 load beats increment", cnt_o, 9);
    ev_in = 1; for (int i = 0; i < 4; i++) cyc(0);
  endtask

  task automatic t_wrap();
    ld_val = 14; ld_en = 1; cyc(0);
    ev_pulse();
    chk("R6 to 15", cnt_o, 15);
    chk("R7 no ovf at 15", ovf_o, 0);
    ev_pulse();
    chk("R6 wrap to 0", cnt_o, 0);
    chk("R7 ovf set", ovf_o, 1);
    ev_pulse();
    chk("R7 ovf sticky", ovf_o, 1);
    ovf_clr = 1; cyc(0);
    chk("R7 ovf cleared", ovf_o, 0);
    ld_val = 15; ld_en = 1; cyc(0);
    ev_in = 0; cyc(0); cyc(0);
    ovf_clr = 1; cyc(0);
    chk("R7 set wins over clear", ovf_o, 1);
    chk("R6 wrap cnt", cnt_o, 0);
    ev_in = 1; for (int i = 0; i < 4; i++) cyc(0);
    ovf_clr = 1; cyc(0);
    ld_val = 15; ld_en = 1; cyc(0);
    ld_val = 0; ld_en = 1; cyc(0);
    chk("R8 load no ovf", ovf_o, 0);
    mode_d = 0; mode_we = 1; cyc(0);
    chk("R9 mode back to timer", mode_o, 0);
  endtask

  initial begin
    t_reset();
    t_prescale();
    t_halt();
    t_event();
    t_load();
    t_wrap();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule